// File: doc/BRIEF.md
# Capacitive Key Detection Filter

This block makes the touch decision for a bank of capacitive sense keys, ten by default. In each sample period the acquisition logic presents one unsigned signal count per key and pulses `sample_valid`. The filter keeps a reference level for each key and compares the signal with it. A touch or a release is reported only after a run of agreeing samples. The reference tracks slow environmental change at two rates, and a key is recalibrated when it stays on too long or when its signal sits far below the reference.

All time-based behaviour counts pulses of `ms_tick`, which is normally one per millisecond. A bench can set the period parameters small so that the timeouts stay short in simulation. The outputs are one debounced bit per key, a wake-style `detect` line of selectable polarity, and a single-cycle strobe that marks any change in the key bits. The host uses the strobe to know when the key bits are worth reading.

Top module: `touch_key_filter`

## Requirements
- R1: After reset every key output is 0. The first `sample_valid` on a used key loads that key's reference with the sample and never reports a touch by itself.
- R2: Delta is the signal minus the reference, computed as a signed value. A key that is off counts a sample as a touch candidate only when delta is 10 or more.
- R3: A key that is on keeps counting its samples as candidates while delta is 8 or more, which is the threshold less a hysteresis of 2.
- R4: With `fast_mode`=0, a key turns on after 6 consecutive candidate samples and turns off after 6 consecutive non-candidate samples. Any sample that breaks the run clears the count.
- R5: With `fast_mode`=1, 2 consecutive candidate samples turn a key on. Release still needs 6 consecutive non-candidate samples.
- R6: While a key is off and has no run in progress, and its last sample is above its reference, the reference rises by 1 after every DRIFT_UP_MS ticks (2000 by default).
- R7: Under the same conditions with the last sample below the reference, the reference falls by 1 after every DRIFT_DN_MS ticks (500 by default).
- R8: No drift is applied while a key is on or while its integrator count is not zero.
- R9: When a key is off and its last delta stays at -6 or lower for NEG_MS consecutive ticks (2000 by default), the reference is set to the last sample. This recalibration takes priority over a drift step that falls due on the same tick.
- R10: `ont_sel` sets the stuck-on limit: 2'b00 gives ONT_SHORT_MS ticks (10000 by default), 2'b01 gives ONT_LONG_MS ticks (60000 by default), and 2'b10 and 2'b11 disable the limit. When a key has been on for the limit, only that key turns off and its reference is set to its last sample.
- R11: `detect` is the OR of all key bits. When `detect_act_low`=1 the OR is inverted.
- R12: `change_strobe` is high for the single cycle that follows any clock edge at which at least one key bit changed.
- R13: A key whose `key_unused` bit is 1 reads as off. While the bit stays 1, the key's samples and ticks leave its reference, its calibration and its timers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ms_tick | input | 1 | Time base pulse, one cycle per millisecond |
| sample_valid | input | 1 | Qualifies `sample_bus` for one cycle |
| sample_bus | input | NKEYS*SIG_W | Signal count per key; key k sits at bits k*SIG_W upward |
| key_unused | input | NKEYS | 1 marks a key as unused |
| fast_mode | input | 1 | 1 selects the short on-run |
| ont_sel | input | 2 | Stuck-on limit select |
| detect_act_low | input | 1 | 1 inverts `detect` |
| key_on | output | NKEYS | Debounced touch state per key |
| detect | output | 1 | Any key on, with the selected polarity |
| change_strobe | output | 1 | One-cycle pulse after any key bit changes |

## Verification
The integrator is driven with random per-key levels chosen around the decision points: just under and just at the on-threshold, on both sides of the release point, and well clear of both. Light noise is added so that runs are often broken. Each sample is compared with a run-length model, and that comparison separates the on and off thresholds, the hysteresis, the fast and normal run lengths, and the reset of a run on a break. Directed sequences then hold a signal above or below the reference for exact tick counts. A probe at delta 9 and delta 10 afterwards shows the reference the key ended with, one count at a time. That probe tells apart up-drift, down-drift, the drift freeze, the negative recalibration and the stuck-on release.

// File: rtl/tkf_pkg.sv
// Package: shared types and helpers for the touch key filter.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package tkf_pkg;

    // Stuck-on limit selection code, as driven on the ont_sel port.
    typedef enum logic [1:0] {
        ONT_SHORT = 2'b00,
        ONT_LONG  = 2'b01,
        ONT_NONE  = 2'b10,
        ONT_RSVD  = 2'b11
    } ont_sel_e;

    // Larger of two integers, for sizing counters.
    function automatic int tkf_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tkf_key_chan.sv
// Module: tkf_key_chan
// The decision logic for one sense key. It holds the reference and the
// consecutive-sample integrator, applies two-rate drift, recalibrates when
// the signal stays far below the reference, and releases a stuck-on key.
// Assumes: sample_valid and ms_tick are single-cycle pulses; all time is
// counted in ms_tick pulses; the timer parameters are 1 or more.
module tkf_key_chan
    import tkf_pkg::*;
#(
    parameter int SIG_W        = 8,
    parameter int THR          = 10,
    parameter int HYST         = 2,
    parameter int NEG_LIM      = 6,
    parameter int ON_RUN       = 6,
    parameter int OFF_RUN      = 6,
    parameter int FAST_RUN     = 2,
    parameter int DRIFT_UP_MS  = 2000,
    parameter int DRIFT_DN_MS  = 500,
    parameter int NEG_MS       = 2000,
    parameter int ONT_SHORT_MS = 10000,
    parameter int ONT_LONG_MS  = 60000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic [SIG_W-1:0] sample,
    input  logic             ms_tick,
    input  logic             unused,
    input  logic             fast_mode,
    input  logic [1:0]       ont_sel,
    output logic             key_on
);
    localparam int DW    = SIG_W + 2;
    localparam int CNT_W = $clog2(tkf_max(tkf_max(ON_RUN, OFF_RUN), FAST_RUN) + 1);
    localparam int TM_W  = $clog2(tkf_max(tkf_max(DRIFT_UP_MS, DRIFT_DN_MS), NEG_MS) + 1);
    localparam int ONT_W = $clog2(tkf_max(ONT_SHORT_MS, ONT_LONG_MS) + 1);

    localparam logic signed [DW-1:0] THR_ON_C  = DW'(THR);
    localparam logic signed [DW-1:0] THR_OFF_C = DW'(THR - HYST);
    localparam logic signed [DW-1:0] NEG_C     = DW'(-NEG_LIM);
    localparam logic [CNT_W:0] ON_RUN_C   = (CNT_W+1)'(ON_RUN);
    localparam logic [CNT_W:0] OFF_RUN_C  = (CNT_W+1)'(OFF_RUN);
    localparam logic [CNT_W:0] FAST_RUN_C = (CNT_W+1)'(FAST_RUN);
    localparam logic [TM_W:0]  UP_C       = (TM_W+1)'(DRIFT_UP_MS);
    localparam logic [TM_W:0]  DN_C       = (TM_W+1)'(DRIFT_DN_MS);
    localparam logic [TM_W:0]  NEGT_C     = (TM_W+1)'(NEG_MS);
    localparam logic [ONT_W:0] SHORT_C    = (ONT_W+1)'(ONT_SHORT_MS);
    localparam logic [ONT_W:0] LONG_C     = (ONT_W+1)'(ONT_LONG_MS);

    logic [SIG_W-1:0] ref_q, ref_n, sig_q, sig_n;
    logic             cal_q, cal_n, on_q, on_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [TM_W-1:0]  drift_q, drift_n, neg_q, neg_n;
    logic [ONT_W-1:0] ont_q, ont_n;

    logic signed [DW-1:0] delta_new, delta_q;
    logic             cand;
    logic [CNT_W:0]   cnt_inc, run_need;
    logic [TM_W:0]    drift_inc, neg_inc;
    logic [ONT_W:0]   ont_inc, ont_lim;
    logic             ont_en;

    assign delta_new = $signed({2'b00, sample}) - $signed({2'b00, ref_q});
    assign delta_q   = $signed({2'b00, sig_q})  - $signed({2'b00, ref_q});
    assign cand      = on_q ? (delta_new >= THR_OFF_C) : (delta_new >= THR_ON_C);
    assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
    assign drift_inc = {1'b0, drift_q} + 1'b1;
    assign neg_inc   = {1'b0, neg_q} + 1'b1;
    assign ont_inc   = {1'b0, ont_q} + 1'b1;
    assign run_need  = on_q ? OFF_RUN_C : (fast_mode ? FAST_RUN_C : ON_RUN_C);
    assign key_on    = on_q;

    // Decode the stuck-on limit; the reserved code behaves as disabled.
    always_comb begin
        case (ont_sel_e'(ont_sel))
            ONT_SHORT: begin ont_lim = SHORT_C; ont_en = 1'b1; end
            ONT_LONG:  begin ont_lim = LONG_C;  ont_en = 1'b1; end
            default:   begin ont_lim = '0;      ont_en = 1'b0; end
        endcase
    end

    // Next state: the integrator acts on samples, timers act on ticks.
    always_comb begin
        ref_n   = ref_q;   sig_n = sig_q;   cal_n = cal_q;   on_n = on_q;
        cnt_n   = cnt_q;   drift_n = drift_q; neg_n = neg_q; ont_n = ont_q;
        if (unused) begin
            on_n = 1'b0; cnt_n = '0; drift_n = '0; neg_n = '0; ont_n = '0;
        end else begin
            if (!on_q) ont_n = '0;
            if (sample_valid) begin
                sig_n = sample;
                if (!cal_q) begin
                    ref_n = sample;
                    cal_n = 1'b1;
                    cnt_n = '0;
                end else if (cand != on_q) begin
                    if (cnt_inc >= run_need) begin
                        on_n  = !on_q;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_inc[CNT_W-1:0];
                    end
                end else begin
                    cnt_n = '0;
                end
            end
            if (ms_tick && cal_q) begin
                // Drift, lowest priority among the reference writers.
                if (on_q || (cnt_q != '0) || (sig_q == ref_q)) begin
                    drift_n = '0;
                end else if (drift_inc >= ((sig_q > ref_q) ? UP_C : DN_C)) begin
                    drift_n = '0;
                    ref_n   = (sig_q > ref_q) ? ref_q + 1'b1 : ref_q - 1'b1;
                end else begin
                    drift_n = drift_inc[TM_W-1:0];
                end
                // Quick recalibration after a sustained drop below reference.
                if (!on_q && (delta_q <= NEG_C)) begin
                    if (neg_inc >= NEGT_C) begin
                        neg_n   = '0;
                        drift_n = '0;
                        ref_n   = sig_q;
                    end else begin
                        neg_n = neg_inc[TM_W-1:0];
                    end
                end else begin
                    neg_n = '0;
                end
                // Stuck-on release, highest priority.
                if (on_q && ont_en) begin
                    if (ont_inc >= ont_lim) begin
                        ont_n = '0;
                        on_n  = 1'b0;
                        cnt_n = '0;
                        ref_n = sig_q;
                    end else begin
                        ont_n = ont_inc[ONT_W-1:0];
                    end
                end
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0; sig_q <= '0; cal_q <= 1'b0; on_q <= 1'b0;
            cnt_q <= '0; drift_q <= '0; neg_q <= '0; ont_q <= '0;
        end else begin
            ref_q <= ref_n; sig_q <= sig_n; cal_q <= cal_n; on_q <= on_n;
            cnt_q <= cnt_n; drift_q <= drift_n; neg_q <= neg_n; ont_q <= ont_n;
        end
    end

    // R13: an unused key reads as off on the next cycle.
    p_unused_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        unused |=> !on_q);
    // R1: no touch before the reference has been loaded.
    p_uncal_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_q |-> !on_q);
    // R4: a key only turns on at a sample.
    p_on_from_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_q) |-> $past(sample_valid));
    // R4: the run count never reaches the longest run length.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt_q} < tkf_max(ON_RUN, OFF_RUN));
    // R6: a calibrated reference changes only on a tick.
    p_ref_tick_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_q && !ms_tick) |=> $stable(ref_q));
    // R8: while on, the reference holds unless the key is released.
    p_frozen_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (on_q && ms_tick) |=> ($stable(ref_q) || !on_q));
endmodule

// File: rtl/tkf_state_merge.sv
// Module: tkf_state_merge
// Merges the per-key states into the detect line and the change strobe.
// Assumes: key_on comes straight from registers.
module tkf_state_merge #(
    parameter int NKEYS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NKEYS-1:0] key_on,
    input  logic             act_low,
    output logic             detect,
    output logic             change_strobe
);
    logic [NKEYS-1:0] prev_q;

    // Keep last cycle's key bits for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= key_on;
    end

    assign change_strobe = |(key_on ^ prev_q);
    assign detect        = act_low ^ (|key_on);
endmodule

// File: rtl/touch_key_filter.sv
// Module: touch_key_filter
// Top of the capacitive key decision filter: one tkf_key_chan per key plus
// the output merge. Assumes sample_bus is stable while sample_valid is high.
module touch_key_filter #(
    parameter int NKEYS        = 10,
    parameter int SIG_W        = 8,
    parameter int THR          = 10,
    parameter int HYST         = 2,
    parameter int NEG_LIM      = 6,
    parameter int ON_RUN       = 6,
    parameter int OFF_RUN      = 6,
    parameter int FAST_RUN     = 2,
    parameter int DRIFT_UP_MS  = 2000,
    parameter int DRIFT_DN_MS  = 500,
    parameter int NEG_MS       = 2000,
    parameter int ONT_SHORT_MS = 10000,
    parameter int ONT_LONG_MS  = 60000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ms_tick,
    input  logic                   sample_valid,
    input  logic [NKEYS*SIG_W-1:0] sample_bus,
    input  logic [NKEYS-1:0]       key_unused,
    input  logic                   fast_mode,
    input  logic [1:0]             ont_sel,
    input  logic                   detect_act_low,
    output logic [NKEYS-1:0]       key_on,
    output logic                   detect,
    output logic                   change_strobe
);
    // One decision channel per key.
    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        tkf_key_chan #(
            .SIG_W(SIG_W), .THR(THR), .HYST(HYST), .NEG_LIM(NEG_LIM),
            .ON_RUN(ON_RUN), .OFF_RUN(OFF_RUN), .FAST_RUN(FAST_RUN),
            .DRIFT_UP_MS(DRIFT_UP_MS), .DRIFT_DN_MS(DRIFT_DN_MS),
            .NEG_MS(NEG_MS), .ONT_SHORT_MS(ONT_SHORT_MS),
            .ONT_LONG_MS(ONT_LONG_MS)
        ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .sample_valid(sample_valid),
            .sample(sample_bus[k*SIG_W +: SIG_W]),
            .ms_tick(ms_tick),
            .unused(key_unused[k]),
            .fast_mode(fast_mode),
            .ont_sel(ont_sel),
            .key_on(key_on[k])
        );
    end

    tkf_state_merge #(.NKEYS(NKEYS)) u_merge (
        .clk(clk), .rst_n(rst_n),
        .key_on(key_on), .act_low(detect_act_low),
        .detect(detect), .change_strobe(change_strobe)
    );
endmodule

// File: tb/sim_touch_key_filter.sv
`timescale 1ns/1ps
module sim_touch_key_filter;
    localparam int NK = 10;
    localparam int SW = 8;
    localparam int UP = 20, DN = 5, NEGT = 20, SHORT = 100, LONG = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, sample_valid = 1'b0, fast_mode = 1'b0, act_low = 1'b0;
    logic [NK*SW-1:0] bus_r = '0;
    logic [NK-1:0] unused_r = '0;
    logic [1:0] ont_sel = 2'b10;
    logic [NK-1:0] key_on;
    logic detect, change_strobe;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    touch_key_filter #(
        .NKEYS(NK), .SIG_W(SW), .DRIFT_UP_MS(UP), .DRIFT_DN_MS(DN),
        .NEG_MS(NEGT), .ONT_SHORT_MS(SHORT), .ONT_LONG_MS(LONG)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sample_valid(sample_valid),
        .sample_bus(bus_r), .key_unused(unused_r), .fast_mode(fast_mode),
        .ont_sel(ont_sel), .detect_act_low(act_low),
        .key_on(key_on), .detect(detect), .change_strobe(change_strobe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_sample();
        @(negedge clk); sample_valid = 1'b1;
        @(negedge clk); sample_valid = 1'b0; #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0; #1;
        end
    endtask

    task automatic set_all(input logic [7:0] v);
        for (int k = 0; k < NK; k++) bus_r[k*SW +: SW] = v;
    endtask

    // Key k gets v for n samples, all other keys stay at 100.
    task automatic send_k(input int k, input logic [7:0] v, input int n);
        set_all(8'd100);
        bus_r[k*SW +: SW] = v;
        for (int i = 0; i < n; i++) pulse_sample();
    endtask

    task automatic reset_cal();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; #1;
        set_all(8'd100);
        pulse_sample();
    endtask

    initial begin
        #(10 * 150000);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Run-length model state for the random phase.
    bit m_on[NK];
    int m_cnt[NK];

    initial begin
        int unsigned seed_v;
        int lvl[NK];
        int levels[8] = '{95, 100, 107, 108, 109, 110, 112, 120};
        logic [NK-1:0] exp_v, old_v;
        seed_v = $urandom(32'd2718);

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1; #1;
        chk("R1 reset key_on", key_on, 0);
        chk("R11 reset detect", detect, 0);
        chk("R12 reset strobe", change_strobe, 0);
        // R1: first sample loads the reference, no touch
        set_all(8'd100); bus_r[0 +: SW] = 8'd200;
        pulse_sample();
        chk("R1 first sample no touch", key_on, 0);
        send_k(0, 8'd209, 6);
        chk("R1 ref from first sample d9", key_on[0], 0);
        send_k(0, 8'd210, 6);
        chk("R1 ref from first sample d10", key_on[0], 1);

        // R2 / R4 / R11 / R12
        reset_cal();
        send_k(0, 8'd109, 10);
        chk("R2 delta 9 stays off", key_on[0], 0);
        send_k(0, 8'd110, 5);
        chk("R4 five samples not enough", key_on[0], 0);
        send_k(0, 8'd110, 1);
        chk("R4 sixth sample on", key_on[0], 1);
        chk("R12 strobe on change", change_strobe, 1);
        chk("R11 detect high", detect, 1);
        @(negedge clk); #1;
        chk("R12 strobe one cycle", change_strobe, 0);
        // R3 hysteresis
        send_k(0, 8'd108, 6);
        chk("R3 delta 8 holds on", key_on[0], 1);
        send_k(0, 8'd107, 5);
        chk("R4 release needs six", key_on[0], 1);
        send_k(0, 8'd107, 1);
        chk("R4 release on sixth", key_on[0], 0);
        chk("R12 strobe on release", change_strobe, 1);
        // R4 broken run
        send_k(0, 8'd110, 5); send_k(0, 8'd109, 1); send_k(0, 8'd110, 5);
        chk("R4 break clears run", key_on[0], 0);
        send_k(0, 8'd110, 1);
        chk("R4 run after break", key_on[0], 1);
        send_k(0, 8'd100, 6);
        // R5 fast mode
        fast_mode = 1'b1;
        send_k(0, 8'd110, 1);
        chk("R5 one sample not enough", key_on[0], 0);
        send_k(0, 8'd110, 1);
        chk("R5 fast on after two", key_on[0], 1);
        send_k(0, 8'd100, 5);
        chk("R5 release still six", key_on[0], 1);
        send_k(0, 8'd100, 1);
        chk("R5 released", key_on[0], 0);
        fast_mode = 1'b0;
        // R11 polarity
        act_low = 1'b1;
        #1 chk("R11 idle active low", detect, 1);
        send_k(0, 8'd110, 6);
        chk("R11 touched active low", detect, 0);
        send_k(0, 8'd100, 6);
        act_low = 1'b0;
        // R13 unused key
        unused_r[3] = 1'b1;
        send_k(3, 8'd200, 8);
        chk("R13 unused held off", key_on[3], 0);
        send_k(3, 8'd105, 1);
        ticks(60);
        unused_r[3] = 1'b0;
        send_k(3, 8'd110, 6);
        chk("R13 no drift while unused", key_on[3], 1);
        send_k(3, 8'd100, 6);

        // R6 drift up
        reset_cal();
        send_k(0, 8'd105, 1);
        ticks(3 * UP);
        send_k(0, 8'd112, 6);
        chk("R6 drift up d9", key_on[0], 0);
        send_k(0, 8'd113, 6);
        chk("R6 drift up d10", key_on[0], 1);
        // R7 drift down
        reset_cal();
        send_k(0, 8'd96, 1);
        ticks(2 * DN);
        send_k(0, 8'd107, 6);
        chk("R7 drift down d9", key_on[0], 0);
        send_k(0, 8'd108, 6);
        chk("R7 drift down d10", key_on[0], 1);
        // R8 freeze during run and while on
        reset_cal();
        send_k(0, 8'd110, 3);
        ticks(2 * UP);
        send_k(0, 8'd110, 2);
        chk("R8 run intact before end", key_on[0], 0);
        send_k(0, 8'd110, 1);
        chk("R8 no drift during run", key_on[0], 1);
        ticks(3 * UP);
        send_k(0, 8'd108, 6);
        chk("R8 no drift while on", key_on[0], 1);
        // R9 quick recalibration
        reset_cal();
        send_k(0, 8'd70, 1);
        ticks(NEGT - 1);
        send_k(0, 8'd106, 6);
        chk("R9 not before limit", key_on[0], 0);
        send_k(0, 8'd107, 6);
        chk("R9 drift down before limit", key_on[0], 1);
        reset_cal();
        send_k(0, 8'd70, 1);
        ticks(NEGT);
        send_k(0, 8'd79, 6);
        chk("R9 recal d9", key_on[0], 0);
        send_k(0, 8'd80, 6);
        chk("R9 recal d10", key_on[0], 1);

        // R10 stuck-on limits
        ont_sel = 2'b00;
        reset_cal();
        send_k(0, 8'd120, 6);
        ticks(SHORT - 1);
        chk("R10 short still on", key_on[0], 1);
        ticks(1);
        chk("R10 short released", key_on[0], 0);
        chk("R12 strobe on timeout", change_strobe, 1);
        send_k(0, 8'd120, 6);
        chk("R10 ref set to signal", key_on[0], 0);
        ont_sel = 2'b01;
        reset_cal();
        send_k(0, 8'd120, 6);
        ticks(LONG - 1);
        chk("R10 long still on", key_on[0], 1);
        ticks(1);
        chk("R10 long released", key_on[0], 0);
        for (int s = 2; s < 4; s++) begin
            ont_sel = 2'(s);
            reset_cal();
            send_k(0, 8'd120, 6);
            ticks(LONG + 20);
            chk("R10 limit disabled", key_on[0], 1);
        end
        ont_sel = 2'b10;

        // Random phase against a run-length model (R2 R3 R4 R5 R11 R12 R13)
        reset_cal();
        unused_r = '0; unused_r[9] = 1'b1;
        for (int k = 0; k < NK; k++) begin m_on[k] = 0; m_cnt[k] = 0; lvl[k] = 100; end
        for (int i = 0; i < 600; i++) begin
            if (i % 60 == 0) begin
                fast_mode = 1'($urandom_range(1));
                act_low   = 1'($urandom_range(1));
            end
            old_v = '0;
            for (int k = 0; k < NK; k++) old_v[k] = m_on[k];
            for (int k = 0; k < NK; k++) begin
                int v, d, need;
                bit c;
                if ($urandom_range(7) == 0) lvl[k] = levels[$urandom_range(7)];
                v = lvl[k];
                if ($urandom_range(3) == 0) v = v + $urandom_range(2) - 1;
                bus_r[k*SW +: SW] = 8'(v);
                d = v - 100;
                if (unused_r[k]) begin
                    m_on[k] = 0; m_cnt[k] = 0;
                end else begin
                    c = m_on[k] ? (d >= 8) : (d >= 10);
                    need = m_on[k] ? 6 : (fast_mode ? 2 : 6);
                    if (c != m_on[k]) begin
                        m_cnt[k]++;
                        if (m_cnt[k] >= need) begin m_on[k] = !m_on[k]; m_cnt[k] = 0; end
                    end else m_cnt[k] = 0;
                end
            end
            pulse_sample();
            exp_v = '0;
            for (int k = 0; k < NK; k++) exp_v[k] = m_on[k];
            chk("R4 R5 random key_on", key_on, exp_v);
            chk("R12 random strobe", change_strobe, (exp_v != old_v));
            chk("R11 random detect", detect, act_low ^ (|exp_v));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule